// File: doc/BRIEF.md
# Dual-Copy Voted Scan Pulse Latch

This block is a word-wide pulse-clocked storage cell that tolerates single upsets. Each bit is held twice, in copy A and copy B, and a per-bit agreement stage (a C-element) drives the output. The output takes a new value only when both copies hold the same value. If one copy is disturbed, the output keeps the last value the two copies agreed on. The next system capture writes both copies again, and the copies then agree once more.

The same two copies also form the scan path. When `scan_mode` is high, copy A acts as the master and copy B as the slave of a shift stage. Alternating strobes move one bit per A/B strobe pair along the word. The bit enters at index 0 and leaves at index WIDTH-1. When `scan_mode` is low, the scan path is cut off and only the system pulse loads data.

Upset-injection inputs flip the bits of either copy, so that the masking can be exercised. A flag marks any cycle in which a system pulse collided with a scan strobe.

Top module: `vsl_top`

## Requirements
- R1: After reset, `q`, `scan_out` and `clk_conflict` are all 0, and both copies hold 0.
- R2: A cycle with `sys_pulse`=1 and `scan_mode`=0 loads `sys_d` into both copies at that clock edge. `q` shows the new word straight after that edge.
- R3: In a cycle with no load and no upset, both copies and `q` keep their values.
- R4: While `scan_mode`=0, `strobe_a`, `strobe_b` and `scan_in` have no effect on either copy.
- R5: While `scan_mode`=1, `sys_pulse` and `sys_d` have no effect on either copy.
- R6: While `scan_mode`=1, `strobe_a` loads copy A. Bit 0 of copy A takes `scan_in`, and bit i of copy A takes bit i-1 of copy B. `strobe_b` loads copy B with copy A, and both strobes may load in the same cycle. `scan_out` is always bit WIDTH-1 of copy B.
- R7: A bit of `upset_a` or `upset_b` set to 1 inverts that bit of that copy at the clock edge. While the two copies differ in a bit, that bit of `q` keeps its value.
- R8: When the two copies agree again in a bit after a load, that bit of `q` takes the agreed value at the same edge.
- R9: `clk_conflict` is 1 in the cycle after a cycle in which `sys_pulse` and either strobe were both 1, in either mode. Otherwise it is 0.
- R10: When a copy is loaded and upset in the same cycle, the load wins and the upset is lost.
- R11: Upsetting the same bit in both copies in one cycle inverts that bit of `q`, because both copies then agree on the flipped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| scan_mode | input | 1 | 1: the copies form a shift stage; 0: system capture |
| sys_pulse | input | 1 | One-cycle system capture pulse |
| scan_in | input | 1 | Serial scan data entering bit 0 |
| strobe_a | input | 1 | Scan master strobe (copy A) |
| strobe_b | input | 1 | Scan slave strobe (copy B) |
| sys_d | input | WIDTH | System data word |
| upset_a | input | WIDTH | Per-bit flip injection into copy A |
| upset_b | input | WIDTH | Per-bit flip injection into copy B |
| q | output | WIDTH | Voted output word |
| scan_out | output | 1 | Serial scan data, bit WIDTH-1 of copy B |
| clk_conflict | output | 1 | Pulse/strobe collision flag, one cycle late |

## Verification
The assertions check every cycle that each copy either holds or takes its loaded data, and that a load overrides an injected flip. They also check that a bit of `q` stays frozen while its copies disagree, that a system capture appears on `q` at once, that scan strobes leave `scan_out` untouched outside scan mode, and that the collision flag matches its cause. Only the bench's scenarios can show the end-to-end properties: a full serial shift through all WIDTH positions, recovery of `q` after a single upset once new data is captured, the loss of masking when both copies flip together, and that stray strobes in system mode left no trace, which the bench confirms by shifting the state out afterwards.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  typedef enum logic {
    PATH_SYSTEM = 1'b0,
    PATH_SCAN   = 1'b1
  } path_e;

  localparam int NUM_COPIES = 2;
  localparam int COPY_A     = 0;
  localparam int COPY_B     = 1;
endpackage

// File: rtl/vsl_ctrl.sv
module vsl_ctrl
  import vsl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scan_mode,
  input  logic  sys_pulse,
  input  logic  strobe_a,
  input  logic  strobe_b,
  output path_e path,
  output logic  load_a,
  output logic  load_b,
  output logic  conflict
);
  logic conflict_nxt;

  always_comb begin
    path   = scan_mode ? PATH_SCAN : PATH_SYSTEM;
    load_a = 1'b0;
    load_b = 1'b0;
    case (path)
      PATH_SCAN: begin
        load_a = strobe_a;
        load_b = strobe_b;
      end
      default: begin
        load_a = sys_pulse;
        load_b = sys_pulse;
      end
    endcase
    conflict_nxt = sys_pulse & (strobe_a | strobe_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict <= 1'b0;
    else        conflict <= conflict_nxt;
  end

  // R9
  conflict_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_pulse && (strobe_a || strobe_b)) |=> conflict);
  // R9
  conflict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $past(sys_pulse && (strobe_a || strobe_b)));
endmodule

// File: rtl/vsl_copy.sv
module vsl_copy #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_nxt;

  always_comb begin
    if (load) state_nxt = din;
    else      state_nxt = state ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nxt;
  end

  // R3
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (flip == '0)) |=> $stable(state));
  // R10
  copy_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == $past(din)));
endmodule

// File: rtl/vsl_celem.sv
module vsl_celem #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic agree;
    always_comb begin
      agree = (a[i] == b[i]);
      q[i]  = agree ? a[i] : hold[i];
    end

    // R7
    vote_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((a[i] != b[i]) && $past(a[i] != b[i])) |-> (q[i] == $past(q[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else        hold <= q;
  end
endmodule

// File: rtl/vsl_top.sv
module vsl_top
  import vsl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_mode,
  input  logic             sys_pulse,
  input  logic             scan_in,
  input  logic             strobe_a,
  input  logic             strobe_b,
  input  logic [WIDTH-1:0] sys_d,
  input  logic [WIDTH-1:0] upset_a,
  input  logic [WIDTH-1:0] upset_b,
  output logic [WIDTH-1:0] q,
  output logic             scan_out,
  output logic             clk_conflict
);
  localparam int MSB = WIDTH - 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  path_e            path;
  logic             load [NUM_COPIES];
  logic [WIDTH-1:0] din  [NUM_COPIES];
  logic [WIDTH-1:0] flip [NUM_COPIES];
  logic [WIDTH-1:0] st   [NUM_COPIES];
  logic [WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  vsl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scan_mode (scan_mode),
    .sys_pulse (sys_pulse),
    .strobe_a  (strobe_a),
    .strobe_b  (strobe_b),
    .path      (path),
    .load_a    (load[COPY_A]),
    .load_b    (load[COPY_B]),
    .conflict  (clk_conflict)
  );

  if (WIDTH > 1) begin : g_chain_wide
    assign chain = {st[COPY_B][WIDTH-2:0], scan_in};
  end else begin : g_chain_single
    assign chain = scan_in;
  end

  always_comb begin
    flip[COPY_A] = upset_a;
    flip[COPY_B] = upset_b;
    if (path == PATH_SCAN) begin
      din[COPY_A] = chain;
      din[COPY_B] = st[COPY_A];
    end else begin
      din[COPY_A] = sys_d;
      din[COPY_B] = sys_d;
    end
  end

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    vsl_copy #(.WIDTH(WIDTH)) u_copy (
      .clk   (clk),
      .rst_n (rst_int_n),
      .load  (load[c]),
      .din   (din[c]),
      .flip  (flip[c]),
      .state (st[c])
    );
  end

  vsl_celem #(.WIDTH(WIDTH)) u_vote (
    .clk   (clk),
    .rst_n (rst_int_n),
    .a     (st[COPY_A]),
    .b     (st[COPY_B]),
    .q     (q)
  );

  assign scan_out = st[COPY_B][MSB];

  // R2
  sys_capture_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sys_pulse && !scan_mode && (upset_a == '0) && (upset_b == '0))
      |=> (q == $past(sys_d)));
  // R4
  scan_isolated_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!scan_mode && !sys_pulse && (upset_b == '0)) |=> $stable(scan_out));
  // R5
  pulse_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_mode && !strobe_a && !strobe_b && (upset_a == '0) && (upset_b == '0))
      |=> $stable(q));
  // R6
  slave_shift_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_mode && strobe_b && !upset_b[MSB])
      |=> (scan_out == $past(st[COPY_A][MSB])));
endmodule

// File: tb/tb_vsl_top.sv
`timescale 1ns/1ps
module tb_vsl_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scan_mode, sys_pulse, scan_in, strobe_a, strobe_b;
  logic [W-1:0] sys_d, upset_a, upset_b;
  logic [W-1:0] q;
  logic         scan_out, clk_conflict;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit m_a [W];
  bit m_b [W];
  bit m_q [W];
  bit m_conf;

  always #4 clk = ~clk;

  vsl_top #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .sys_pulse(sys_pulse),
    .scan_in(scan_in), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .sys_d(sys_d), .upset_a(upset_a), .upset_b(upset_b),
    .q(q), .scan_out(scan_out), .clk_conflict(clk_conflict)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] pack(input bit v [W]);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sys_pulse = 0; strobe_a = 0; strobe_b = 0; scan_in = 0;
    upset_a = '0; upset_b = '0;
  endtask

  // one clock: reference advances at the edge, outputs compared mid-cycle
  task automatic tick(input string tag);
    bit na [W];
    bit nb [W];
    bit la, lb;
    @(posedge clk);
    la = scan_mode ? strobe_a : sys_pulse;
    lb = scan_mode ? strobe_b : sys_pulse;
    for (int i = 0; i < W; i++) begin
      if (scan_mode) begin
        na[i] = (i == 0) ? scan_in : m_b[i-1];
        nb[i] = m_a[i];
      end else begin
        na[i] = sys_d[i];
        nb[i] = sys_d[i];
      end
      if (!la) na[i] = m_a[i] ^ upset_a[i];
      if (!lb) nb[i] = m_b[i] ^ upset_b[i];
    end
    m_conf = sys_pulse && (strobe_a || strobe_b);
    for (int i = 0; i < W; i++) begin
      m_a[i] = na[i];
      m_b[i] = nb[i];
      if (m_a[i] == m_b[i]) m_q[i] = m_a[i];
    end
    @(negedge clk);
    check(tag, "q", q, pack(m_q));
    check(tag, "scan_out", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, m_b[W-1]});
    check(tag, "clk_conflict", {{(W-1){1'b0}}, clk_conflict}, {{(W-1){1'b0}}, m_conf});
    idle_inputs();
  endtask

  task automatic capture(input string tag, input logic [W-1:0] v);
    sys_pulse = 1; sys_d = v;
    tick(tag);
  endtask

  task automatic shift_pair(input string tag, input bit b);
    strobe_a = 1; scan_in = b;
    tick(tag);
    strobe_b = 1;
    tick(tag);
  endtask

  initial begin
    for (int i = 0; i < W; i++) begin m_a[i] = 0; m_b[i] = 0; m_q[i] = 0; end
    m_conf = 0;
    rst_n = 0; scan_mode = 0; sys_d = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick("R1");

    // R2 normal capture, R3 hold
    capture("R2", 8'hA5);
    repeat (3) tick("R3");
    capture("R2", 8'h3C);

    // R4 stray strobes in system mode, changing sys_d without pulse
    strobe_a = 1; scan_in = 1; tick("R4");
    strobe_b = 1; scan_in = 1; tick("R4");
    sys_d = 8'hFF; tick("R4");

    // R7 single upset in copy A then B, R8 recovery
    upset_a = 8'h08; tick("R7");
    repeat (2) tick("R7");
    capture("R8", 8'h5A);
    upset_b = 8'h81; tick("R7");
    tick("R7");
    capture("R8", 8'hC3);

    // R10 upset together with load
    sys_pulse = 1; sys_d = 8'h0F; upset_a = 8'hFF; upset_b = 8'h10; tick("R10");
    tick("R10");

    // R11 same bit flipped in both copies
    upset_a = 8'h02; upset_b = 8'h02; tick("R11");
    tick("R11");

    // R9 collisions in both modes
    sys_pulse = 1; sys_d = 8'h66; strobe_a = 1; tick("R9");
    tick("R9");
    scan_mode = 1;
    sys_pulse = 1; strobe_b = 1; tick("R9");
    tick("R9");

    // R5 pulse ignored in scan mode
    sys_pulse = 1; sys_d = 8'h99; tick("R5");
    tick("R5");

    // R6 shift a pattern in, then out; reveals earlier state too
    for (int k = 0; k < W; k++) shift_pair("R6", bit'((8'b1011_0010 >> k) & 1));
    for (int k = 0; k < W; k++) shift_pair("R6", 1'b0);
    strobe_a = 1; strobe_b = 1; scan_in = 1; tick("R6");
    tick("R6");

    // back to system mode
    scan_mode = 0;
    capture("R2", 8'h81);
    strobe_a = 1; scan_in = 1; tick("R4");
    scan_mode = 1;
    repeat (W) shift_pair("R4", 1'b0);
    scan_mode = 0;
    capture("R8", 8'h42);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule